// File: doc/BRIEF.md
# Beacon Timing and TSF Unit

This block keeps a 64-bit microsecond time base (the TSF) and four beacon-related target timers: next beacon target, DMA beacon alert, software beacon alert and end of the ATIM window. The TSF advances by one on each cycle that the microsecond tick enable is high. Each timer holds a 16-bit target. While beacons are enabled, a timer raises its own event bit when a 16-bit slice of the TSF equals its target. In the cycle after that, the timer steps its target forward by the beacon period. The four timers step independently of one another. If the TSF jumps past a timer's target, that timer stays silent until the 16-bit slice wraps around to the target again.

Software reaches the block through a single-cycle write port and a read port with one cycle of latency. Loading a new TSF value takes two writes: the low word, then the high word. This stands in for TSF adjustment from received beacons. A coherent 64-bit read is a low-word read followed by a high-word read. The control word holds the beacon period, the enable bit and a TSF-clear bit. The clear bit acts once per write and is never stored.

Top module: `bcn_tsf_unit`

## Requirements
- R1: The 64-bit TSF resets to zero and increments by exactly one, with carry into the upper 32 bits, on every clock where us_tick_i is high. Otherwise it holds its value.
- R2: A write to address 0 (TSF low) only stages the value and leaves the TSF unchanged. A write to address 1 (TSF high) loads the TSF with {high data, staged low}.
- R3: A read returns data on rd_data_o one cycle after rd_en_i. Reading address 0 returns TSF bits [31:0] and captures TSF bits [63:32] into a shadow register. Reading address 1 returns that shadow, not the live upper word.
- R4: The control word at address 6 holds the beacon period in bits [15:0] (in TU), the beacon enable in bit 23 and the TSF-clear command in bit 24. A read-back returns period and enable, with bit 24 always 0.
- R5: Each write to address 6 with bit 24 set clears the TSF to zero once. Clear takes priority over a load and a tick in the same cycle. No clear stays pending, so the TSF counts up from zero on the following ticks.
- R6: Timers 0 and 3 compare their target against TSF bits [25:10] (whole TU). Timers 1 and 2 compare against TSF bits [22:7] (1/8 TU). bcn_evt_o[i] is high in the cycle the compare of timer i matches while beacons are enabled.
- R7: On the clock edge that ends a match cycle, the matching timer's target advances modulo 2^16: by the period for timers 0 and 3, or by eight times the period for timers 1 and 2. Targets of timers that did not match are unchanged.
- R8: While the enable bit is clear, no event is raised and no target changes except by a software write.
- R9: Only the 16-bit TSF slice takes part in a compare. A timer left behind by a forward TSF jump stays silent, and it fires again once the slice wraps around to its target, whatever the TSF bits above the slice hold.
- R10: Addresses 2, 3, 4 and 5 write and read timers 0, 1, 2 and 3. A write takes data bits [15:0], and a read returns the target zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-microsecond tick enable for the TSF |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data, valid one cycle after rd_en_i |
| bcn_evt_o | output | 4 | Per-timer match events: 0 next beacon, 1 DMA alert, 2 software alert, 3 ATIM end |

## Verification
A write lands on the next rising edge. A TSF load or clear therefore shows in the very next read, and a timer match caused by a load raises its event in the cycle that follows the edge on which the high word was written. The event then drops one edge later, when the target advances. Read data is captured on the edge after rd_en_i. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each result is checked exactly one edge after its cause. The tick input is held low during setup and raised for a counted number of edges, which makes every TSF value and every match cycle exact.

// File: rtl/bt_pkg.sv
package bt_pkg;
  parameter int unsigned TSF_W    = 64;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned TMR_W    = 16;
  parameter int unsigned NUM_TMR  = 4;
  parameter int unsigned TU_LSB   = 10;
  parameter int unsigned FINE_LSB = 7;
  parameter int unsigned FINE_SH  = TU_LSB - FINE_LSB;
  parameter int unsigned EN_BIT   = 23;
  parameter int unsigned CLR_BIT  = 24;

  typedef enum logic [2:0] {
    A_TSF_LO = 3'd0,
    A_TSF_HI = 3'd1,
    A_TMR0   = 3'd2,
    A_TMR1   = 3'd3,
    A_TMR2   = 3'd4,
    A_TMR3   = 3'd5,
    A_CTRL   = 3'd6
  } bt_addr_e;

  function automatic logic is_fine(int unsigned idx);
    return (idx == 1) || (idx == 2);
  endfunction
endpackage

// File: rtl/bt_tsf_counter.sv
module bt_tsf_counter #(
  parameter int unsigned W = bt_pkg::TSF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] tsf_o
);
  logic [W-1:0] tsf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tsf_q <= '0;
    else if (clr_i)  tsf_q <= '0;
    else if (load_i) tsf_q <= load_val_i;
    else if (tick_i) tsf_q <= tsf_q + 1'b1;
  end

  assign tsf_o = tsf_q;

  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !clr_i && !load_i |=> tsf_q == $past(tsf_q) + 1'b1);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i && !load_i |=> $stable(tsf_q));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> tsf_q == $past(load_val_i));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tsf_q == '0);
endmodule

// File: rtl/bt_target_timer.sv
module bt_target_timer #(
  parameter int unsigned W     = bt_pkg::TMR_W,
  parameter int unsigned SHIFT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] field_i,
  input  logic [W-1:0] period_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  output logic         fire_o,
  output logic [W-1:0] target_o
);
  logic [W-1:0] target_q;
  logic [W-1:0] step;

  assign step   = period_i << SHIFT;
  assign fire_o = en_i && (field_i == target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     target_q <= '0;
    else if (wr_i)   target_q <= wr_val_i;
    else if (fire_o) target_q <= target_q + step;
  end

  assign target_o = target_q;

  p_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> en_i);
  p_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !wr_i |=> target_q == W'($past(target_q) + $past(step)));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o && !wr_i |=> $stable(target_q));
  p_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> target_q == $past(wr_val_i));
endmodule

// File: rtl/bcn_tsf_unit.sv
module bcn_tsf_unit
  import bt_pkg::*;
#(
  parameter int unsigned TW = bt_pkg::TSF_W,
  parameter int unsigned DW = bt_pkg::DATA_W,
  parameter int unsigned MW = bt_pkg::TMR_W,
  parameter int unsigned NT = bt_pkg::NUM_TMR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          us_tick_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [2:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [NT-1:0] bcn_evt_o
);
  localparam int unsigned HW = TW - DW;

  logic [DW-1:0] lo_stage_q;
  logic [HW-1:0] hi_shadow_q;
  logic [MW-1:0] period_q;
  logic          en_q;
  logic [DW-1:0] rd_q;
  logic [TW-1:0] tsf;
  logic          tsf_load, tsf_clr, ctrl_wr;
  logic [MW-1:0] tgt [NT];

  assign ctrl_wr  = wr_en_i && (wr_addr_i == A_CTRL);
  assign tsf_clr  = ctrl_wr && wr_data_i[CLR_BIT];
  assign tsf_load = wr_en_i && (wr_addr_i == A_TSF_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_stage_q <= '0;
      period_q   <= '0;
      en_q       <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_TSF_LO) lo_stage_q <= wr_data_i;
      if (ctrl_wr) begin
        period_q <= wr_data_i[MW-1:0];
        en_q     <= wr_data_i[EN_BIT];
      end
    end
  end

  bt_tsf_counter #(.W(TW)) u_tsf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (us_tick_i),
    .clr_i      (tsf_clr),
    .load_i     (tsf_load),
    .load_val_i ({wr_data_i[HW-1:0], lo_stage_q}),
    .tsf_o      (tsf)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [2:0]  ADDR  = 3'(A_TMR0 + i);
    localparam int unsigned LSB   = is_fine(i) ? FINE_LSB : TU_LSB;
    localparam int unsigned SHIFT = is_fine(i) ? FINE_SH : 0;
    logic          fire;
    logic [MW-1:0] target;

    bt_target_timer #(.W(MW), .SHIFT(SHIFT)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_q),
      .field_i  (tsf[LSB +: MW]),
      .period_i (period_q),
      .wr_i     (wr_en_i && (wr_addr_i == ADDR)),
      .wr_val_i (wr_data_i[MW-1:0]),
      .fire_o   (fire),
      .target_o (target)
    );
    assign bcn_evt_o[i] = fire;
    assign tgt[i]       = target;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q        <= '0;
      hi_shadow_q <= '0;
    end else if (rd_en_i) begin
      unique case (rd_addr_i)
        A_TSF_LO: begin
          rd_q        <= tsf[DW-1:0];
          hi_shadow_q <= tsf[TW-1:DW];
        end
        A_TSF_HI: rd_q <= DW'(hi_shadow_q);
        A_TMR0:   rd_q <= DW'(tgt[0]);
        A_TMR1:   rd_q <= DW'(tgt[1]);
        A_TMR2:   rd_q <= DW'(tgt[2]);
        A_TMR3:   rd_q <= DW'(tgt[3]);
        A_CTRL: begin
          rd_q         <= DW'(period_q);
          rd_q[EN_BIT] <= en_q;
        end
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;

  p_ctrl_clr_rb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_addr_i == A_CTRL) |=> !rd_data_o[CLR_BIT]);
  p_shadow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_addr_i == A_TSF_LO) |=> hi_shadow_q == $past(tsf[TW-1:DW]));
  p_no_evt_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> bcn_evt_o == '0);
endmodule

// File: tb/bcn_tsf_unit_bench.sv
`timescale 1ns/1ps
module bcn_tsf_unit_bench;
  localparam int EN  = 1 << 23;
  localparam int CLR = 1 << 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  evt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcn_tsf_unit u_bcn_tsf_unit (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .bcn_evt_o(evt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_tsf(logic [31:0] hi, logic [31:0] lo);
    wr(3'd0, lo);
    wr(3'd1, hi);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 reset evt", 32'(evt), 0);
    rd(3'd0, d); check("R1 reset tsf lo", d, 0);
    rd(3'd1, d); check("R1 reset tsf hi", d, 0);
    rd(3'd6, d); check("R4 reset ctrl", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    ticks(5);
    rd(3'd0, d); check("R1 count lo", d, 5);
    rd(3'd1, d); check("R1 count hi", d, 0);
    load_tsf(32'h0, 32'hFFFF_FFFF);
    ticks(1);
    rd(3'd0, d); check("R1 carry lo", d, 0);
    rd(3'd1, d); check("R1 carry hi", d, 1);
  endtask

  task automatic t_load;
    logic [31:0] d;
    load_tsf(32'h0, 32'd5);
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, d); check("R2 low write stages only", d, 5);
    wr(3'd1, 32'h0000_000A);
    rd(3'd0, d); check("R2 load lo", d, 32'h1234_5678);
    rd(3'd1, d); check("R2 load hi", d, 32'h0000_000A);
  endtask

  task automatic t_coherent;
    logic [31:0] d;
    load_tsf(32'd7, 32'hFFFF_FFF0);
    rd(3'd0, d); check("R3 lo read", d, 32'hFFFF_FFF0);
    ticks(32);
    rd(3'd1, d); check("R3 hi from shadow", d, 7);
    rd(3'd0, d); check("R3 lo after wrap", d, 32'h10);
    rd(3'd1, d); check("R3 hi recaptured", d, 8);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(3'(2 + i), 32'hFFFF_8000);
    rd(3'd2, d); check("R10 timer write 16 bits", d, 32'h8000);
    wr(3'd6, EN | CLR | 100);
    rd(3'd6, d); check("R4 ctrl readback", d, EN | 100);
    rd(3'd0, d); check("R5 clear via ctrl", d, 0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    load_tsf(32'd3, 32'd100);
    wr(3'd6, EN | CLR | 100);
    wr(3'd6, EN | CLR | 100);
    rd(3'd0, d); check("R5 cleared lo", d, 0);
    rd(3'd1, d); check("R5 cleared hi", d, 0);
    ticks(4);
    rd(3'd0, d); check("R5 no pending clear", d, 4);
  endtask

  task automatic t_fire_tu;
    logic [31:0] d;
    wr(3'd2, 3);
    check("R6 no early event", 32'(evt), 0);
    load_tsf(32'h0, 3 * 1024);
    check("R6 timer0 event", 32'(evt), 4'b0001);
    @(negedge clk);
    check("R6 event one cycle", 32'(evt), 0);
    rd(3'd2, d); check("R7 timer0 advance", d, 103);
  endtask

  task automatic t_fire_fine;
    logic [31:0] d;
    wr(3'd3, 50);
    load_tsf(32'h0, 50 * 128);
    check("R6 timer1 fine event", 32'(evt), 4'b0010);
    rd(3'd3, d); check("R7 timer1 advance x8", d, 850);
    wr(3'd4, 60);
    load_tsf(32'h0, 60 * 128 - 2);
    ticks(1);
    check("R6 timer2 not yet", 32'(evt), 0);
    ticks(1);
    check("R6 timer2 on tick", 32'(evt), 4'b0100);
    rd(3'd4, d); check("R7 timer2 advance x8", d, 860);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(3'd6, 100);
    wr(3'd5, 9);
    load_tsf(32'h0, 9 * 1024);
    check("R8 no event when disabled", 32'(evt), 0);
    @(negedge clk);
    rd(3'd5, d); check("R8 timer3 held", d, 9);
    wr(3'd6, EN | 100);
    check("R8 event after enable", 32'(evt), 4'b1000);
    rd(3'd5, d); check("R7 timer3 advance", d, 109);
  endtask

  task automatic t_strand;
    logic [31:0] d;
    wr(3'd2, 2);
    load_tsf(32'h0, 5 * 1024);
    check("R9 stranded timer silent", 32'(evt), 0);
    ticks(20);
    check("R9 still silent", 32'(evt), 0);
    load_tsf(32'h0, 32'h0400_0000 + 2 * 1024);
    check("R9 fires after slice wrap", 32'(evt), 4'b0001);
    rd(3'd2, d); check("R9 advance after wrap", d, 102);
    rd(3'd5, d); check("R7 timer3 independent", d, 109);
    wr(3'd6, EN | 32);
    wr(3'd2, 32'hFFF0);
    load_tsf(32'h0, 32'hFFF0 << 10);
    check("R7 timer0 near top", 32'(evt), 4'b0001);
    rd(3'd2, d); check("R7 target wraps mod 2^16", d, 32'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_load();
    t_coherent();
    t_ctrl();
    t_clear();
    t_fire_tu();
    t_fire_fine();
    t_enable();
    t_strand();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule